// File: doc/BRIEF.md
# Two-Level Page Table Walker

This unit turns a 32-bit virtual address into a 28-bit physical address by reading a two-level page table that lives in memory. A caller presents the address with an access kind (read, write or execute) and a privilege flag through a valid/ready handshake. The unit captures the request together with the root table's page number, reads the first-level entry, then the second-level entry, and checks the leaf entry's permission bits against the request. It answers with a one-cycle done pulse that carries either the physical address or a fault flag with a two-bit cause.

Table reads go out on a narrow memory port. A one-cycle request strobe carries the entry address, and the memory answers with an acknowledge that carries the 32-bit entry. Only one translation is in flight at a time. Fault handling, caching of translations and the final data access belong to other blocks.

Top module: `xlat_walker`

## Requirements
- R1: A synchronous active-high `rst` leaves the unit idle: `req_ready` is 1, `rsp_done` is 0 and `mem_req` is 0.
- R2: A request is taken in the cycle where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until the done cycle, and it is 1 again in the cycle after the done cycle.
- R3: In the cycle after acceptance, `mem_req` is 1 for exactly one cycle with `mem_addr` = {root_ppn, 12'h000} + 4 * vaddr[31:22]. The root page number and the request fields are sampled at acceptance, and later changes to those inputs do not affect the walk.
- R4: A first-level entry with bit 0 (present) equal to 0 ends the walk with no second read. In the cycle after its acknowledge, the done pulse shows fault 1 and cause 2'b01.
- R5: A present first-level entry starts a second read in the cycle after its acknowledge, at {entry[27:12], 12'h000} + 4 * vaddr[21:12].
- R6: A second-level entry with bit 0 equal to 0 gives fault 1 and cause 2'b10.
- R7: The access code 2'b00 (read) needs leaf bit 1. The code 2'b01 (write) needs bit 2. The code 2'b10 (execute) needs bit 3. The code 2'b11 is always refused. A refused access gives fault 1 and cause 2'b11.
- R8: Leaf bit 4 marks a supervisor-only page. With it set, a request with `req_priv` = 0 is refused with cause 2'b11. With `req_priv` = 1, bit 4 has no effect.
- R9: An allowed access gives fault 0, cause 2'b00 and `rsp_paddr` = {leaf[27:12], vaddr[11:0]}. For example, virtual page 7 mapped to page 32 returns page number 32 with the unchanged offset.
- R10: On any fault, `rsp_paddr` is all zeros.
- R11: `rsp_done` is high for exactly one cycle. That cycle is the one after the acknowledge that ends the walk, and the result outputs are valid during it.
- R12: The acknowledge may arrive any number of cycles after the strobe, and `mem_addr` holds its value until then. An acknowledge outside a waiting state is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_vaddr | input | 32 | Virtual address |
| req_acc | input | 2 | Access kind: 00 read, 01 write, 10 execute, 11 reserved |
| req_priv | input | 1 | 1 for supervisor, 0 for user |
| root_ppn | input | 16 | Page number of the first-level table |
| mem_req | output | 1 | One-cycle entry read strobe |
| mem_addr | output | 28 | Byte address of the entry being read |
| mem_ack | input | 1 | Entry read answered, data on mem_rdata |
| mem_rdata | input | 32 | Entry word returned by memory |
| rsp_done | output | 1 | One-cycle result pulse |
| rsp_paddr | output | 28 | Physical address, zero on a fault |
| rsp_fault | output | 1 | Translation failed |
| rsp_cause | output | 2 | 01 first level absent, 10 second level absent, 11 permission |

## Verification
The embedded properties assume that memory raises `mem_ack` for one cycle per strobe and only while the unit is waiting. They also assume that `rst` is held from time zero until the first edges have passed. The bench's memory model answers each strobe exactly once after a chosen delay of zero to three cycles and drops the acknowledge right after the consuming edge. Its only deliberate exception is a stray acknowledge sent while the unit is idle, which is there to show that it is ignored. After acceptance the bench scrambles the request and root inputs, so that a walk which re-read them would be caught at the ports.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_L1_REQ,
      ST_L1_WAIT,
      ST_L2_REQ,
      ST_L2_WAIT,
      ST_DONE
   } walk_st_e;

   // entry flag positions
   localparam int BIT_VLD = 0;
   localparam int BIT_RD  = 1;
   localparam int BIT_WR  = 2;
   localparam int BIT_EX  = 3;
   localparam int BIT_SUP = 4;
   localparam int FLAG_W  = 5;

   // access kinds
   localparam logic [1:0] ACC_RD  = 2'b00;
   localparam logic [1:0] ACC_WR  = 2'b01;
   localparam logic [1:0] ACC_EX  = 2'b10;

   // fault causes
   localparam logic [1:0] CAUSE_NONE = 2'b00;
   localparam logic [1:0] CAUSE_L1   = 2'b01;
   localparam logic [1:0] CAUSE_L2   = 2'b10;
   localparam logic [1:0] CAUSE_PERM = 2'b11;

endpackage

// File: rtl/xlat_addr.sv
// Entry address former: table page number joined with a scaled index.
module xlat_addr #(
   parameter int PA_W      = 28,
   parameter int PAGE_BITS = 12,
   parameter int IDX_W     = 10,
   parameter int ENT_LG2   = 2
) (
   input  logic [PA_W-PAGE_BITS-1:0] tbl_ppn,
   input  logic [IDX_W-1:0]          idx,
   output logic [PA_W-1:0]           ent_addr
);
   localparam int PAD = PAGE_BITS - IDX_W - ENT_LG2;

   generate
      if (PAD < 0) begin : g_bad
         $error("xlat_addr: index does not fit in one table page");
      end else if (PAD == 0) begin : g_tight
         assign ent_addr = {tbl_ppn, idx, {ENT_LG2{1'b0}}};
      end else begin : g_padded
         assign ent_addr = {tbl_ppn, {PAD{1'b0}}, idx, {ENT_LG2{1'b0}}};
      end
   endgenerate
endmodule

// File: rtl/xlat_perm.sv
// Leaf permission check against access kind and privilege.
module xlat_perm
   import xlat_pkg::*;
#(
   parameter bit ENFORCE_SUP = 1'b1
) (
   input  logic [FLAG_W-1:0] flags,
   input  logic [1:0]        acc,
   input  logic              priv,
   output logic              allow
);
   logic kind_ok;
   logic level_ok;

   always_comb begin
      case (acc)
         ACC_RD:  kind_ok = flags[BIT_RD];
         ACC_WR:  kind_ok = flags[BIT_WR];
         ACC_EX:  kind_ok = flags[BIT_EX];
         default: kind_ok = 1'b0;
      endcase
   end

   generate
      if (ENFORCE_SUP) begin : g_sup
         assign level_ok = priv | ~flags[BIT_SUP];
      end else begin : g_nosup
         assign level_ok = 1'b1;
      end
   endgenerate

   assign allow = flags[BIT_VLD] & kind_ok & level_ok;
endmodule

// File: rtl/xlat_fsm.sv
// Walk sequencer.
module xlat_fsm
   import xlat_pkg::*;
(
   input  logic     clk,
   input  logic     rst,
   input  logic     req_fire,
   input  logic     mem_ack,
   input  logic     l1_present,
   output walk_st_e st
);
   walk_st_e st_n;

   always_comb begin
      st_n = st;
      case (st)
         ST_IDLE:    if (req_fire) st_n = ST_L1_REQ;
         ST_L1_REQ:  st_n = ST_L1_WAIT;
         ST_L1_WAIT: if (mem_ack) st_n = l1_present ? ST_L2_REQ : ST_DONE;
         ST_L2_REQ:  st_n = ST_L2_WAIT;
         ST_L2_WAIT: if (mem_ack) st_n = ST_DONE;
         ST_DONE:    st_n = ST_IDLE;
         default:    st_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) st <= ST_IDLE;
      else     st <= st_n;
   end

   AST_WAIT_STALL: assert property (@(posedge clk) disable iff (rst)
      ((st == ST_L1_WAIT || st == ST_L2_WAIT) && !mem_ack) |=> (st == $past(st))); // R12
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (st == ST_IDLE && !req_fire) |=> (st == ST_IDLE)); // R2
endmodule

// File: rtl/xlat_walker.sv
// Two-level translation walker top.
module xlat_walker
   import xlat_pkg::*;
#(
   parameter int VA_W        = 32,
   parameter int PA_W        = 28,
   parameter int PAGE_BITS   = 12,
   parameter int PTE_W       = 32,
   parameter bit ENFORCE_SUP = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      req_valid,
   output logic                      req_ready,
   input  logic [VA_W-1:0]           req_vaddr,
   input  logic [1:0]                req_acc,
   input  logic                      req_priv,
   input  logic [PA_W-PAGE_BITS-1:0] root_ppn,
   output logic                      mem_req,
   output logic [PA_W-1:0]           mem_addr,
   input  logic                      mem_ack,
   input  logic [PTE_W-1:0]          mem_rdata,
   output logic                      rsp_done,
   output logic [PA_W-1:0]           rsp_paddr,
   output logic                      rsp_fault,
   output logic [1:0]                rsp_cause
);
   localparam int IDX_W   = (VA_W - PAGE_BITS) / 2;
   localparam int PPN_W   = PA_W - PAGE_BITS;
   localparam int ENT_LG2 = $clog2(PTE_W / 8);

   generate
      if ((VA_W - PAGE_BITS) % 2 != 0) begin : g_chk_split
         $error("xlat_walker: page number must split into two equal indexes");
      end
      if (PTE_W < PA_W) begin : g_chk_pte
         $error("xlat_walker: entry too narrow for a page number");
      end
      if (PAGE_BITS < FLAG_W) begin : g_chk_flags
         $error("xlat_walker: flags overlap the page number field");
      end
   endgenerate

   walk_st_e               st;
   logic                   req_fire;
   logic                   lvl1;
   logic [VA_W-1:0]        va_q;
   logic [1:0]             acc_q;
   logic                   priv_q;
   logic [PPN_W-1:0]       root_q;
   logic [PPN_W-1:0]       nxt_q;
   logic [PPN_W-1:0]       tbl_sel;
   logic [IDX_W-1:0]       idx_sel;
   logic [PPN_W-1:0]       ent_ppn;
   logic                   ent_present;
   logic                   leaf_allow;
   logic                   unused_pte;

   assign req_ready   = (st == ST_IDLE);
   assign req_fire    = req_valid & req_ready;
   assign rsp_done    = (st == ST_DONE);
   assign mem_req     = (st == ST_L1_REQ) || (st == ST_L2_REQ);
   assign lvl1        = (st == ST_L1_REQ) || (st == ST_L1_WAIT);
   assign ent_ppn     = mem_rdata[PAGE_BITS +: PPN_W];
   assign ent_present = mem_rdata[BIT_VLD];
   assign unused_pte  = ^mem_rdata;

   assign tbl_sel = lvl1 ? root_q : nxt_q;
   assign idx_sel = lvl1 ? va_q[VA_W-1 -: IDX_W] : va_q[PAGE_BITS +: IDX_W];

   xlat_fsm u_fsm (
      .clk        (clk),
      .rst        (rst),
      .req_fire   (req_fire),
      .mem_ack    (mem_ack),
      .l1_present (ent_present),
      .st         (st)
   );

   xlat_addr #(
      .PA_W      (PA_W),
      .PAGE_BITS (PAGE_BITS),
      .IDX_W     (IDX_W),
      .ENT_LG2   (ENT_LG2)
   ) u_addr (
      .tbl_ppn  (tbl_sel),
      .idx      (idx_sel),
      .ent_addr (mem_addr)
   );

   xlat_perm #(
      .ENFORCE_SUP (ENFORCE_SUP)
   ) u_perm (
      .flags (mem_rdata[FLAG_W-1:0]),
      .acc   (acc_q),
      .priv  (priv_q),
      .allow (leaf_allow)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         va_q      <= '0;
         acc_q     <= '0;
         priv_q    <= 1'b0;
         root_q    <= '0;
         nxt_q     <= '0;
         rsp_paddr <= '0;
         rsp_fault <= 1'b0;
         rsp_cause <= CAUSE_NONE;
      end else begin
         if (req_fire) begin
            va_q   <= req_vaddr;
            acc_q  <= req_acc;
            priv_q <= req_priv;
            root_q <= root_ppn;
         end
         if (st == ST_L1_WAIT && mem_ack) begin
            if (!ent_present) begin
               rsp_fault <= 1'b1;
               rsp_cause <= CAUSE_L1;
               rsp_paddr <= '0;
            end else begin
               nxt_q <= ent_ppn;
            end
         end
         if (st == ST_L2_WAIT && mem_ack) begin
            if (!ent_present) begin
               rsp_fault <= 1'b1;
               rsp_cause <= CAUSE_L2;
               rsp_paddr <= '0;
            end else if (!leaf_allow) begin
               rsp_fault <= 1'b1;
               rsp_cause <= CAUSE_PERM;
               rsp_paddr <= '0;
            end else begin
               rsp_fault <= 1'b0;
               rsp_cause <= CAUSE_NONE;
               rsp_paddr <= {ent_ppn, va_q[PAGE_BITS-1:0]};
            end
         end
      end
   end

   AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (rst)
      req_fire |=> !req_ready); // R2
   AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (rst)
      mem_req |=> !mem_req); // R3
   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
      (mem_req || (!req_ready && !rsp_done && !mem_ack)) |=> $stable(mem_addr)); // R12
   AST_L1_ABSENT: assert property (@(posedge clk) disable iff (rst)
      (st == ST_L1_WAIT && mem_ack && !ent_present) |=> (rsp_done && rsp_cause == CAUSE_L1)); // R4
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
      rsp_done |=> (!rsp_done && req_ready)); // R11
   AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (rst)
      (rsp_done && rsp_fault) |-> (rsp_paddr == '0 && rsp_cause != CAUSE_NONE)); // R10
   AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (rst)
      (rsp_done && !rsp_fault) |-> (rsp_paddr[PAGE_BITS-1:0] == va_q[PAGE_BITS-1:0])); // R9
endmodule

// File: tb/sim_xlat_walker.sv
`timescale 1ns/1ps
module sim_xlat_walker;
   logic        clk = 1'b0;
   logic        rst;
   logic        req_valid;
   logic        req_ready;
   logic [31:0] req_vaddr;
   logic [1:0]  req_acc;
   logic        req_priv;
   logic [15:0] root_ppn;
   logic        mem_req;
   logic [27:0] mem_addr;
   logic        mem_ack;
   logic [31:0] mem_rdata;
   logic        rsp_done;
   logic [27:0] rsp_paddr;
   logic        rsp_fault;
   logic [1:0]  rsp_cause;

   int n_run  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   xlat_walker u0 (
      .clk(clk), .rst(rst),
      .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
      .req_acc(req_acc), .req_priv(req_priv), .root_ppn(root_ppn),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .rsp_done(rsp_done), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause)
   );

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", what, act, exp);
      end
   endtask

   // one memory answer after dly waiting cycles
   task automatic answer(input int dly, input logic [31:0] word, input logic [27:0] a);
      @(negedge clk);
      chk("R3 strobe lasts one cycle", mem_req, 0);
      for (int k = 0; k < dly; k++) begin
         chk("R12 address held while waiting", mem_addr, a);
         @(negedge clk);
      end
      mem_ack = 1'b1;
      mem_rdata = word;
      @(negedge clk);
      mem_ack = 1'b0;
      mem_rdata = 32'hDEAD_BEEF;
   endtask

   task automatic xlat(input logic [31:0] va, input logic [1:0] acc, input logic pr,
                       input logic [15:0] root, input logic [31:0] l1w, input logic [31:0] l2w,
                       input int dly);
      logic [27:0] a1, a2, pa_e;
      logic [1:0]  c_e;
      logic        kind_ok, lvl_ok;
      string       tg;
      a1 = {root, 12'h000} + {16'h0, va[31:22], 2'b00};
      a2 = {l1w[27:12], 12'h000} + {16'h0, va[21:12], 2'b00};
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = va; req_acc = acc; req_priv = pr; root_ppn = root;
      chk("R2 ready before accept", req_ready, 1);
      @(negedge clk);
      req_valid = 1'b0; req_vaddr = ~va; req_acc = ~acc; req_priv = ~pr; root_ppn = ~root;
      chk("R2 ready low after accept", req_ready, 0);
      chk("R3 first strobe", mem_req, 1);
      chk("R3 first entry address", mem_addr, a1);
      answer(dly, l1w, a1);
      if (!l1w[0]) begin
         chk("R4 no second read", mem_req, 0);
         chk("R11 done after first ack", rsp_done, 1);
         chk("R4 fault flag", rsp_fault, 1);
         chk("R4 cause 01", rsp_cause, 2'b01);
         chk("R10 address zero on fault", rsp_paddr, 0);
      end else begin
         chk("R5 second strobe", mem_req, 1);
         chk("R5 second entry address", mem_addr, a2);
         chk("R2 ready low mid walk", req_ready, 0);
         answer(dly, l2w, a2);
         case (acc)
            2'b00:   kind_ok = l2w[1];
            2'b01:   kind_ok = l2w[2];
            2'b10:   kind_ok = l2w[3];
            default: kind_ok = 1'b0;
         endcase
         lvl_ok = !l2w[4] || pr;
         if (!l2w[0]) begin
            c_e = 2'b10; pa_e = '0; tg = "R6";
         end else if (!(kind_ok && lvl_ok)) begin
            c_e = 2'b11; pa_e = '0; tg = (kind_ok && !lvl_ok) ? "R8" : "R7";
         end else begin
            c_e = 2'b00; pa_e = {l2w[27:12], va[11:0]}; tg = "R9";
         end
         chk("R11 done after second ack", rsp_done, 1);
         chk({tg, " fault flag"}, rsp_fault, (c_e != 2'b00));
         chk({tg, " cause"}, rsp_cause, c_e);
         chk((c_e != 2'b00) ? "R10 address zero on fault" : "R9 physical address", rsp_paddr, pa_e);
      end
      @(negedge clk);
      chk("R11 done is one cycle", rsp_done, 0);
      chk("R2 ready after done", req_ready, 1);
   endtask

   initial begin
      rst = 1'b1; req_valid = 1'b0; req_vaddr = '0; req_acc = '0; req_priv = 1'b0;
      root_ppn = '0; mem_ack = 1'b0; mem_rdata = '0;
      repeat (3) @(negedge clk);
      chk("R1 ready in reset", req_ready, 1);
      chk("R1 no done in reset", rsp_done, 0);
      chk("R1 no strobe in reset", mem_req, 0);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 idle after reset", {req_ready, rsp_done, mem_req}, 3'b100);

      // stray acknowledge while idle
      mem_ack = 1'b1; mem_rdata = 32'hFFFF_FFFF;
      @(negedge clk);
      mem_ack = 1'b0;
      chk("R12 stray ack: no strobe", mem_req, 0);
      chk("R12 stray ack: no done", rsp_done, 0);
      chk("R12 stray ack: still ready", req_ready, 1);

      // virtual page 7 mapped to page 32
      xlat(32'h0000_7ABC, 2'b00, 1'b0, 16'h0100, 32'h0020_0001, 32'h0002_0003, 1);
      chk("R9 page 7 to page 32", rsp_paddr, 28'h0020ABC);

      // sweep over access kinds, privilege and leaf flags
      for (int k = 0; k < 256; k++) begin
         logic [31:0] va, l1w, l2w, m1, m2;
         logic [4:0]  fl;
         fl  = k[4:0];
         va  = (k * 32'h9E37_79B9) ^ 32'h1234_5678;
         m1  = (k * 32'h0001_7003) ^ 32'hC35A_0000;
         m2  = (k * 32'h0013_3001) ^ 32'h5A5A_5000;
         l1w = {m1[31:12], 11'h0, 1'b1};
         l2w = {m2[31:12], 7'h0, fl};
         xlat(va, k[6:5], k[7], 16'hA5A5 ^ 16'(k * 257), l1w, l2w, k % 4);
      end

      // absent first-level entries with other bits set
      for (int k = 0; k < 16; k++) begin
         xlat(32'hFFC0_0000 - (k * 32'h0040_1001), k[1:0], k[2], 16'(k * 4099),
              32'hFFFF_FFFE, 32'hFFFF_FFFF, k % 3);
      end

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule